// File: doc/BRIEF.md
# SCCB Camera Register Configurator

This block loads a fixed set of image-sensor register settings over a two-wire serial camera control bus. After a single start pulse it walks an internal case-based table. Each table word is 16 bits wide and holds a register address and the value for that register. Every word becomes its own bus write: a start condition, the device write address, the register address, the value, and a stop condition. After each of the three bytes the sensor gets an acknowledge slot.

The clock pin is always driven by the block and is never tri-stated. The data pin is open-drain. The block presents an intended level and an enable, and the pad pulls the line low only while the enable is set. An external pull-up supplies the high level. The line is read back on a separate input so the acknowledge can be sampled.

A refused acknowledge does not stop the run. It sets a sticky error flag and the table walk goes on to the end. A done flag then marks completion. The bit rate comes from a quarter-phase divide parameter. With the default of 32 clocks per quarter at 50 MHz, the bus clock is about 390 kHz.

Top module: `sccb_cfg_top`

## Requirements
- R1: After reset and whenever no run is active, scl_o is 1, sda_oe_o is 0, and busy_o is 0.
- R2: A start_i pulse while idle begins a run. On the next clock edge busy_o goes to 1 and done_o and err_o are cleared. The first bus event is a start condition, in which the data line falls while scl_o is high.
- R3: Outside start and stop conditions, the data line changes only while scl_o is low.
- R4: Each write sends three bytes, most significant bit first: the device write address DEV_ID (default 0x42), then the register address, then the value.
- R5: In the ninth clock of every byte, sda_oe_o is 0. If the line is high when sampled in that slot, err_o is set and stays set until the next run starts. The run still continues.
- R6: Each table entry is written in its own bus cycle, which ends with a stop condition (the data line rises while scl_o is high). A run therefore produces exactly one start and one stop per entry.
- R7: The table has 6 entries, sent in this index order as (address, value): (0x12,0x46), (0x0D,0x41), (0x11,0x01), (0x3E,0xCF), (0x66,0x00), (0x8E,0x7A).
- R8: Each bit lasts four quarters of QTR_CYCLES clocks each. scl_o is low in quarter 0, high in quarters 1 and 2, and low in quarter 3, so consecutive rising edges of scl_o within a byte are 4*QTR_CYCLES clocks apart.
- R9: After the stop of the last entry, done_o goes to 1 in the same cycle that busy_o goes to 0. The bus is then idle, and done_o holds until the next run starts.
- R10: A start_i pulse during a run is ignored. The run's byte stream and its start and stop counts are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a configuration run |
| sda_i | input | 1 | Sampled level of the data line |
| scl_o | output | 1 | Bus clock, always driven |
| sda_o | output | 1 | Intended data level; the pad drives it only while sda_oe_o is 1 |
| sda_oe_o | output | 1 | Data pad enable; 1 pulls the line low |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | The last run completed |
| err_o | output | 1 | Sticky flag: some acknowledge slot of the current or last run was high |

## Verification
The hardest situation to reach from the ports is a refused acknowledge on one chosen byte, especially the last acknowledge of the last entry. There, the error flag and the done flag change within a few quarters of each other. The bench drives this with a bus-level sensor model that decodes starts, stops and bits from the pins. It refuses the acknowledge according to a per-byte mask, and the mask is either directed (only the final slot, or every slot) or drawn at random. A second start pulse injected in the middle of a run checks that the frame stream is unchanged.

// File: rtl/sccb_cfg_pkg.sv
package sccb_cfg_pkg;

    // Sequencer states in bus order
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_ID,
        ST_ACK1,
        ST_REG,
        ST_ACK2,
        ST_DATA,
        ST_ACK3,
        ST_STOP
    } seq_state_e;

    localparam int unsigned CFG_ENTRIES = 6;
    localparam int unsigned CFG_IDX_W   = $clog2(CFG_ENTRIES);

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] value;
    } cfg_entry_t;

    typedef struct packed {
        seq_state_e           state;
        logic [1:0]           qtr;
        logic [2:0]           bitn;
        logic [7:0]           shift;
        logic [CFG_IDX_W-1:0] idx;
        logic                 busy;
        logic                 done;
        logic                 err;
    } seq_regs_t;

endpackage

// File: rtl/sccb_cfg_rom.sv
module sccb_cfg_rom
    import sccb_cfg_pkg::*;
(
    input  logic [CFG_IDX_W-1:0] idx_i,
    output cfg_entry_t           entry_o,
    output logic                 last_o
);

    always_comb begin
        case (idx_i)
            CFG_IDX_W'(0): entry_o = '{addr: 8'h12, value: 8'h46};
            CFG_IDX_W'(1): entry_o = '{addr: 8'h0D, value: 8'h41};
            CFG_IDX_W'(2): entry_o = '{addr: 8'h11, value: 8'h01};
            CFG_IDX_W'(3): entry_o = '{addr: 8'h3E, value: 8'hCF};
            CFG_IDX_W'(4): entry_o = '{addr: 8'h66, value: 8'h00};
            CFG_IDX_W'(5): entry_o = '{addr: 8'h8E, value: 8'h7A};
            default:       entry_o = '{addr: 8'h00, value: 8'h00};
        endcase
    end

    assign last_o = (idx_i == CFG_IDX_W'(CFG_ENTRIES - 1));

endmodule

// File: rtl/sccb_qtr_timer.sv
module sccb_qtr_timer #(
    parameter int unsigned QTR_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);

    localparam int unsigned CNT_W = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QTR_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run_i && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = run_i && (cnt_q == CNT_MAX);

    // A quarter lasts QTR_CYCLES clocks, so ticks never come back to back
    p_tick_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && (QTR_CYCLES > 1)) |=> !tick_o);

    p_cnt_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/sccb_pin_map.sv
module sccb_pin_map
    import sccb_cfg_pkg::*;
(
    input  seq_state_e state_i,
    input  logic [1:0] qtr_i,
    input  logic       bit_i,
    output logic       scl_o,
    output logic       lvl_o,
    output logic       drive_o
);

    always_comb begin
        scl_o = 1'b1;
        lvl_o = 1'b1;
        unique case (state_i)
            ST_IDLE: begin
                scl_o = 1'b1;
                lvl_o = 1'b1;
            end
            ST_START: begin
                // SCL high for three quarters, SDA falls in quarter 2
                scl_o = (qtr_i != 2'd3);
                lvl_o = (qtr_i < 2'd2);
            end
            ST_STOP: begin
                // SCL rises in quarter 1, SDA rises in quarter 2
                scl_o = (qtr_i != 2'd0);
                lvl_o = (qtr_i >= 2'd2);
            end
            ST_ACK1, ST_ACK2, ST_ACK3: begin
                scl_o = (qtr_i == 2'd1) || (qtr_i == 2'd2);
                lvl_o = 1'b1;
            end
            default: begin
                scl_o = (qtr_i == 2'd1) || (qtr_i == 2'd2);
                lvl_o = bit_i;
            end
        endcase
        drive_o = !lvl_o;
    end

endmodule

// File: rtl/sccb_cfg_seq.sv
module sccb_cfg_seq
    import sccb_cfg_pkg::*;
#(
    parameter logic [7:0] DEV_ID = 8'h42
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 tick_i,
    input  logic                 sda_i,
    input  cfg_entry_t           entry_i,
    input  logic                 last_i,
    output logic [CFG_IDX_W-1:0] idx_o,
    output logic                 scl_o,
    output logic                 sda_o,
    output logic                 sda_oe_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o
);

    localparam logic [7:0] WR_ADDR = {DEV_ID[7:1], 1'b0};

    seq_regs_t cur_q, nx_d;
    logic      scl_d, lvl_d, drv_d;
    logic      scl_q, lvl_q, drv_q;
    logic      in_ack;

    assign in_ack = (cur_q.state == ST_ACK1) || (cur_q.state == ST_ACK2) ||
                    (cur_q.state == ST_ACK3);

    always_comb begin
        nx_d = cur_q;
        if (cur_q.state == ST_IDLE) begin
            if (start_i) begin
                nx_d.state = ST_START;
                nx_d.qtr   = 2'd0;
                nx_d.idx   = '0;
                nx_d.busy  = 1'b1;
                nx_d.done  = 1'b0;
                nx_d.err   = 1'b0;
            end
        end else if (tick_i) begin
            nx_d.qtr = cur_q.qtr + 2'd1;
            if ((cur_q.qtr == 2'd2) && in_ack && sda_i) begin
                nx_d.err = 1'b1;
            end
            if (cur_q.qtr == 2'd3) begin
                unique case (cur_q.state)
                    ST_START: begin
                        nx_d.state = ST_ID;
                        nx_d.shift = WR_ADDR;
                        nx_d.bitn  = 3'd7;
                    end
                    ST_ID, ST_REG, ST_DATA: begin
                        if (cur_q.bitn == 3'd0) begin
                            nx_d.state = (cur_q.state == ST_ID)  ? ST_ACK1 :
                                         (cur_q.state == ST_REG) ? ST_ACK2 : ST_ACK3;
                        end else begin
                            nx_d.shift = {cur_q.shift[6:0], 1'b0};
                            nx_d.bitn  = cur_q.bitn - 3'd1;
                        end
                    end
                    ST_ACK1: begin
                        nx_d.state = ST_REG;
                        nx_d.shift = entry_i.addr;
                        nx_d.bitn  = 3'd7;
                    end
                    ST_ACK2: begin
                        nx_d.state = ST_DATA;
                        nx_d.shift = entry_i.value;
                        nx_d.bitn  = 3'd7;
                    end
                    ST_ACK3: begin
                        nx_d.state = ST_STOP;
                    end
                    ST_STOP: begin
                        if (last_i) begin
                            nx_d.state = ST_IDLE;
                            nx_d.busy  = 1'b0;
                            nx_d.done  = 1'b1;
                        end else begin
                            nx_d.state = ST_START;
                            nx_d.idx   = cur_q.idx + 1'b1;
                        end
                    end
                    default: nx_d.state = ST_IDLE;
                endcase
            end
        end
    end

    // Pin levels are decoded from the next state and registered
    sccb_pin_map u_pins (
        .state_i (nx_d.state),
        .qtr_i   (nx_d.qtr),
        .bit_i   (nx_d.shift[7]),
        .scl_o   (scl_d),
        .lvl_o   (lvl_d),
        .drive_o (drv_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, qtr: 2'd0, bitn: 3'd0, shift: 8'h00,
                       idx: '0, busy: 1'b0, done: 1'b0, err: 1'b0};
            scl_q <= 1'b1;
            lvl_q <= 1'b1;
            drv_q <= 1'b0;
        end else begin
            cur_q <= nx_d;
            scl_q <= scl_d;
            lvl_q <= lvl_d;
            drv_q <= drv_d;
        end
    end

    assign idx_o    = cur_q.idx;
    assign scl_o    = scl_q;
    assign sda_o    = lvl_q;
    assign sda_oe_o = drv_q;
    assign busy_o   = cur_q.busy;
    assign done_o   = cur_q.done;
    assign err_o    = cur_q.err;

    p_idle_bus_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_IDLE) |-> (scl_q && !drv_q && !cur_q.busy));

    p_sda_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_q && $past(scl_q) &&
         !(cur_q.state inside {ST_START, ST_STOP, ST_IDLE}) &&
         !($past(cur_q.state) inside {ST_START, ST_STOP, ST_IDLE}))
        |-> (drv_q == $past(drv_q)));

    p_ack_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_ack |-> !drv_q);

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.err && cur_q.busy) |=> cur_q.err);

    p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cur_q.done && cur_q.busy));

    p_idx_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.idx != $past(cur_q.idx)) |->
        ((cur_q.idx == $past(cur_q.idx) + 1'b1) || (cur_q.idx == '0)));

    p_busy_ignores_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.busy && start_i && !tick_i) |=> $stable(cur_q.idx));

endmodule

// File: rtl/sccb_cfg_top.sv
module sccb_cfg_top
    import sccb_cfg_pkg::*;
#(
    parameter int unsigned QTR_CYCLES = 32,
    parameter logic [7:0]  DEV_ID     = 8'h42
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic sda_oe_o,
    output logic busy_o,
    output logic done_o,
    output logic err_o
);

    logic                 tick;
    logic [CFG_IDX_W-1:0] idx;
    cfg_entry_t           entry;
    logic                 last;

    sccb_qtr_timer #(.QTR_CYCLES(QTR_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_o),
        .tick_o (tick)
    );

    sccb_cfg_rom u_rom (
        .idx_i   (idx),
        .entry_o (entry),
        .last_o  (last)
    );

    sccb_cfg_seq #(.DEV_ID(DEV_ID)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .tick_i   (tick),
        .sda_i    (sda_i),
        .entry_i  (entry),
        .last_i   (last),
        .idx_o    (idx),
        .scl_o    (scl_o),
        .sda_o    (sda_o),
        .sda_oe_o (sda_oe_o),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .err_o    (err_o)
    );

endmodule

// File: tb/tb_sccb_cfg_top.sv
module tb_sccb_cfg_top;

    localparam int QTR = 4;
    localparam int N   = 6;
    localparam logic [7:0] DEV = 8'h42;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic scl, sda_o, sda_oe, busy, done, err;
    logic slv_drive = 1'b0;
    logic sda_line;

    assign sda_line = (sda_oe ? sda_o : 1'b1) & ~slv_drive;

    sccb_cfg_top #(.QTR_CYCLES(QTR), .DEV_ID(DEV)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sda_i(sda_line),
        .scl_o(scl), .sda_o(sda_o), .sda_oe_o(sda_oe),
        .busy_o(busy), .done_o(done), .err_o(err)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Bus-level sensor model
    logic [3*N-1:0] nack_mask = '0;
    logic [7:0] got [N][3];
    logic [7:0] sh = 8'h00;
    logic pscl = 1'b1, psda = 1'b1, in_txn = 1'b0, ackph = 1'b0;
    int bitc = 0, bytei = 0, ntx = 0, nstart = 0, nstop = 0, badframe = 0;
    int per_bad = 0, last_rise = 0;

    always @(scl or sda_line) begin
        if (scl === 1'b1 && pscl && psda && sda_line === 1'b0) begin
            nstart++; in_txn = 1'b1; bitc = 0; bytei = 0; ackph = 1'b0;
        end else if (scl === 1'b1 && pscl && !psda && sda_line === 1'b1) begin
            nstop++;
            if (bytei == 3) ntx++; else badframe++;
            in_txn = 1'b0;
        end else if (scl === 1'b1 && !pscl) begin
            if (in_txn && bitc < 8) begin
                sh = {sh[6:0], sda_line};
                bitc++;
                if (bitc >= 2 && (cyc - last_rise) != 4*QTR) per_bad++;
                last_rise = cyc;
            end
        end else if (scl === 1'b0 && pscl) begin
            if (in_txn) begin
                if (ackph) begin
                    slv_drive = 1'b0; ackph = 1'b0; bitc = 0; bytei++;
                end else if (bitc == 8 && bytei < 3) begin
                    if (ntx < N) begin
                        got[ntx][bytei] = sh;
                        slv_drive = !nack_mask[ntx*3 + bytei];
                    end
                    ackph = 1'b1;
                end
            end
        end
        pscl = (scl === 1'b1);
        psda = (sda_line !== 1'b0);
    end

    function automatic logic [7:0] exp_addr(int i);
        case (i)
            0: return 8'h12; 1: return 8'h0D; 2: return 8'h11;
            3: return 8'h3E; 4: return 8'h66; default: return 8'h8E;
        endcase
    endfunction

    function automatic logic [7:0] exp_val(int i);
        case (i)
            0: return 8'h46; 1: return 8'h41; 2: return 8'h01;
            3: return 8'hCF; 4: return 8'h00; default: return 8'h7A;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [3*N-1:0] mask, input bit midstart, input int gap);
        int waited;
        nack_mask = mask;
        ntx = 0; nstart = 0; nstop = 0; badframe = 0; per_bad = 0;
        repeat (gap) @(negedge clk);
        chk(scl === 1'b1 && sda_oe === 1'b0 && busy === 1'b0, "R1", "idle bus", {scl, sda_oe, busy}, 3'b100);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && done === 1'b0 && err === 1'b0, "R2", "run begin flags", {busy, done, err}, 3'b100);
        if (midstart) begin
            repeat (700) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (done !== 1'b1 && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        chk(done === 1'b1 && busy === 1'b0, "R9", "done after run", {done, busy}, 2'b10);
        chk(scl === 1'b1 && sda_oe === 1'b0, "R9", "bus idle at done", {scl, sda_oe}, 2'b10);
        chk(nstart == N && nstop == N && badframe == 0, midstart ? "R10" : "R6",
            "start/stop count", nstart*256 + nstop, N*256 + N);
        chk(ntx == N, "R6", "frames", ntx, N);
        for (int i = 0; i < N; i++) begin
            chk(got[i][0] === DEV, "R4", $sformatf("id byte %0d", i), got[i][0], DEV);
            chk(got[i][1] === exp_addr(i), "R7", $sformatf("reg byte %0d", i), got[i][1], exp_addr(i));
            chk(got[i][2] === exp_val(i), "R7", $sformatf("value byte %0d", i), got[i][2], exp_val(i));
        end
        chk(err === (|mask), "R5", "error flag", err, |mask);
        chk(per_bad == 0, "R8", "scl period faults", per_bad, 0);
        repeat (60) @(negedge clk);
        chk(done === 1'b1 && busy === 1'b0 && nstart == N, "R9", "done holds", {done, busy}, 2'b10);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl === 1'b1 && sda_oe === 1'b0 && busy === 1'b0 && done === 1'b0 && err === 1'b0,
            "R1", "reset state", {scl, sda_oe, busy, done, err}, 5'b10000);
        run('0, 1'b0, 3);
        run({1'b1, {(3*N-1){1'b0}}}, 1'b0, 5);
        run({(3*N){1'b1}}, 1'b0, 2);
        run('0, 1'b1, 4);
        for (int r = 0; r < 6; r++) begin
            logic [3*N-1:0] m;
            m = '0;
            for (int b = 0; b < 3*N; b++) m[b] = ($urandom % 8) == 0;
            run(m, ($urandom % 2) == 1, 1 + ($urandom % 20));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule